// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the bit clock of a synchronous serial master from the system clock. Two dividers are chained. The first is a prescaler that only takes even values. The second is a rate divider that divides by one plus its setting. The generator also applies the clock polarity and phase selection. On each serial clock edge it raises a one-cycle strobe that tells the shift engine when to drive the next bit and when to capture the incoming bit.

The shift engine holds `run_i` high for as long as it wants clock edges. The clock runs only while the port enable is also high. When it is not running, the serial clock rests at the level set by the polarity bit. The divisor settings come from a 16-bit control word and an 8-bit prescale value. Working out those settings from a target frequency is done outside this block.

Top module: `spi_sclk_gen`

## Requirements
- R1: During reset `sclk_o`, `launch_o` and `sample_o` are all 0.
- R2: In any cycle that follows a clock edge at which `en_i` or `run_i` was low, `sclk_o` equals control bit 7 (polarity) and both strobes are 0.
- R3: While running, every SCLK half period lasts H = (P/2)*(1+N) system clocks. P is the prescale value with bit 0 cleared, and N is control bits 15:8. The first transition comes H cycles after the first edge at which running is seen.
- R4: Bit 0 of `prescale_i` has no effect. Prescale values 0 and 1 act as 2.
- R5: N may take any value from 0 to 255. With P=2 and N=0, SCLK toggles on every system clock, which gives a period of 2 cycles.
- R6: With P=254 and N=255, the SCLK period is 254*256 = 65024 system clocks.
- R7: With control bit 6 (phase) at 0, `sample_o` pulses on the leading SCLK edge (the edge away from the rest level) and `launch_o` pulses on the trailing edge.
- R8: With control bit 6 at 1, `launch_o` pulses on the leading edge and `sample_o` pulses on the trailing edge.
- R9: A strobe is exactly one system clock wide, appears in the same cycle that `sclk_o` changes, and `launch_o` and `sample_o` are never high together.
- R10: With `en_i` low, no SCLK edges occur even while `run_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| prescale_i | input | 8 | Even prescale divisor (bit 0 ignored) |
| ctrl_word_i | input | 16 | [15:8] rate setting N, [7] polarity, [6] phase, [5:0] unused |
| run_i | input | 1 | Clock request from the shift engine |
| sclk_o | output | 1 | Serial bit clock |
| launch_o | output | 1 | Strobe: drive the next output bit |
| sample_o | output | 1 | Strobe: capture the input bit |

## Verification
The bench covers several corner cases. At the fastest setting (P=2, N=0) the clock must toggle every cycle; an off-by-one in either counter would stretch the half period to two cycles. Odd prescale values and the values 0 and 1 are used, because a design that honoured bit 0 or let zero through would change the period or hang. When run is dropped in the middle of a half period, a design that let the clock coast would leave SCLK away from its rest level. All four polarity and phase combinations are run, because swapping the leading and trailing strobes would make the shift engine capture data on the wrong edge. The slowest setting is run for a full period to expose counter widths that are too narrow.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned RATE_W = 8;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              cpol;
    logic              cpha;
  } sclk_cfg_t;

  function automatic sclk_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
    sclk_cfg_t c;
    c.rate = w[15:8];
    c.cpol = w[7];
    c.cpha = w[6];
    return c;
  endfunction
endpackage

// File: rtl/spi_sclk_prescale.sv
module spi_sclk_prescale #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,   // prescale / 2
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q, lim;

  // a zero half count behaves as one (prescale 2)
  assign lim    = (half_i == '0) ? '0 : half_i - 1'b1;
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_sclk_rate_div.sv
module spi_sclk_rate_div #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              half_o
);
  logic [RATE_W-1:0] cnt_q;

  assign half_o = tick_i && (cnt_q >= rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= half_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic half_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sclk_o,
  output logic launch_o,
  output logic sample_o
);
  logic sclk_q, launch_q, sample_q, leading;

  assign leading = (sclk_q == cpol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else if (!run_i) begin
      sclk_q   <= cpol_i;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      if (half_i) sclk_q <= ~sclk_q;
      launch_q <= half_i && (leading == cpha_i);
      sample_q <= half_i && (leading != cpha_i);
    end
  end

  assign sclk_o   = sclk_q;
  assign launch_o = launch_q;
  assign sample_o = sample_q;
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic              run_i,
  output logic              sclk_o,
  output logic              launch_o,
  output logic              sample_o
);
  localparam int unsigned HALF_W = PRE_W - 1;

  sclk_cfg_t cfg;
  logic      active, tick, half_end;
  logic      unused_bits;

  assign cfg         = decode_ctrl(ctrl_word_i);
  assign active      = en_i && run_i;
  assign unused_bits = ^{prescale_i[0], ctrl_word_i[5:0]};

  spi_sclk_prescale #(.HALF_W(HALF_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .half_i (prescale_i[PRE_W-1:1]),
    .tick_o (tick)
  );

  spi_sclk_rate_div #(.RATE_W(RATE_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .tick_i (tick),
    .rate_i (cfg.rate),
    .half_o (half_end)
  );

  spi_sclk_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active),
    .half_i   (half_end),
    .cpol_i   (cfg.cpol),
    .cpha_i   (cfg.cpha),
    .sclk_o   (sclk_o),
    .launch_o (launch_o),
    .sample_o (sample_o)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        run_i,
  input logic [15:0] ctrl_word_i,
  input logic        sclk_o,
  input logic        launch_o,
  input logic        sample_o
);
  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && run_i) |=> (sclk_o == $past(ctrl_word_i[7])) && !launch_o && !sample_o);

  assert_strobe_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && sample_o));

  assert_strobe_on_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o || sample_o) |-> (sclk_o != $past(sclk_o)));

  // R7 / R8: sample edge direction follows phase
  assert_sample_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> ((sclk_o != ctrl_word_i[7]) == !ctrl_word_i[6]));

  assert_launch_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> ((sclk_o != ctrl_word_i[7]) == ctrl_word_i[6]));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .run_i       (run_i),
  .ctrl_word_i (ctrl_word_i),
  .sclk_o      (sclk_o),
  .launch_o    (launch_o),
  .sample_o    (sample_o)
);

// File: tb/spi_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_sclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  pre = 8'd2;
  logic [15:0] ctrl = 16'h0000;
  logic        sclk, launch, sample;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  logic  cmp_on = 1'b0;

  // model state
  int   m_cnt = 0;
  logic m_sclk = 1'b0, m_launch = 1'b0, m_sample = 1'b0;

  always #10 clk = ~clk;

  spi_sclk_gen u_spi_sclk_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .prescale_i  (pre),
    .ctrl_word_i (ctrl),
    .run_i       (run),
    .sclk_o      (sclk),
    .launch_o    (launch),
    .sample_o    (sample)
  );

  function automatic int half_len(input logic [7:0] p, input logic [7:0] n);
    int h;
    h = (p & 8'hFE) / 2;
    if (h == 0) h = 1;
    return h * (n + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sclk = 0; m_launch = 0; m_sample = 0;
    end else if (!(en && run)) begin
      m_cnt = 0; m_sclk = ctrl[7]; m_launch = 0; m_sample = 0;
    end else if (m_cnt == half_len(pre, ctrl[15:8]) - 1) begin
      logic lead;
      lead     = (m_sclk == ctrl[7]);
      m_cnt    = 0;
      m_sclk   = ~m_sclk;
      m_launch = (lead == ctrl[6]);
      m_sample = (lead != ctrl[6]);
    end else begin
      m_cnt    = m_cnt + 1;
      m_launch = 0;
      m_sample = 0;
    end
  end

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t {sclk,launch,sample} actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk)
    if (cmp_on) check(tag, {sclk, launch, sample}, {m_sclk, m_launch, m_sample});

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic burst(input string req, input logic [7:0] p, input logic [7:0] n,
                       input logic cpol, input logic cpha, input int cycles);
    run = 1'b0;
    tag = req;
    pre = p;
    ctrl = {n, cpol, cpha, 6'b101010};
    wait_cyc(3);
    run = 1'b1;
    wait_cyc(cycles);
    run = 1'b0;
    wait_cyc(3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #5;
    check("R1", {sclk, launch, sample}, 3'b000);
    #30;
    check("R1", {sclk, launch, sample}, 3'b000);
    @(posedge clk); #5;
    rst_n = 1'b1;
    cmp_on = 1'b1;
    en = 1'b1;

    burst("R3", 8'd4, 8'd2, 1'b0, 1'b0, 60);
    burst("R3", 8'd6, 8'd0, 1'b1, 1'b0, 40);
    burst("R4", 8'd5, 8'd1, 1'b0, 1'b1, 40);
    burst("R4", 8'd0, 8'd0, 1'b1, 1'b1, 12);
    burst("R4", 8'd1, 8'd3, 1'b0, 1'b0, 30);
    burst("R5", 8'd2, 8'd0, 1'b0, 1'b0, 16);
    burst("R5", 8'd2, 8'd255, 1'b1, 1'b0, 600);
    burst("R7", 8'd2, 8'd1, 1'b0, 1'b0, 24);
    burst("R7", 8'd4, 8'd0, 1'b1, 1'b0, 24);
    burst("R8", 8'd2, 8'd1, 1'b0, 1'b1, 24);
    burst("R8", 8'd4, 8'd0, 1'b1, 1'b1, 24);
    // R2: drop run mid half period, then restart
    burst("R2", 8'd8, 8'd3, 1'b1, 1'b0, 23);
    burst("R2", 8'd8, 8'd3, 1'b0, 1'b1, 37);

    // R10: enable low blocks edges while run held high
    tag = "R10";
    en = 1'b0;
    run = 1'b1;
    pre = 8'd2;
    ctrl = 16'h0080;
    wait_cyc(20);
    check("R10", {sclk, launch, sample}, 3'b100);
    en = 1'b1;
    wait_cyc(8);
    en = 1'b0;
    wait_cyc(4);
    check("R10", {sclk, launch, sample}, 3'b100);
    run = 1'b0;
    en = 1'b1;

    burst("R6", 8'd254, 8'd255, 1'b0, 1'b0, 65100);

    cmp_on = 1'b0;
    finish_run();
  end
endmodule